// File: doc/BRIEF.md
# Auto-mute filter update sequencer

This block makes sure that changes to the tone and crossover filter settings of an audio path are never heard as clicks. Writes to the filter configuration word are first held in a shadow copy. While auto-mute is enabled, a held value that differs from the active one starts a sequence. The gain of the three main signal paths ramps down to silence. At the silent floor the shadow is copied into the active settings. The gain then ramps back up. The filter arithmetic is done elsewhere; it reads the active settings and multiplies by the gain level that this block drives.

The same ramp serves direct mute requests, which come either from a device pin or from a register bit. The ramp follows an S-shaped curve that is read from a small table, one entry per phase. It is timed by an external tick, with one of four selectable ramp lengths. Once a ramp has started it always finishes. A status flag is high for the whole time the gain is below unity, from the start of muting until de-muting has ended.

Top module: `automute_seq`

## Requirements
- R1: After reset the gain output is at full scale (all ones), the status flag is 0, and the active settings are all zero.
- R2: With auto-mute enabled, a written configuration that differs from the active one leaves the active settings unchanged until the gain has reached 0. The new value is applied at the floor, and the gain then ramps back to full scale.
- R3: Writes that arrive while a sequence runs overwrite the shadow, and only the last value written is applied. A write that arrives during the rise starts a further sequence once the rise has ended.
- R4: With auto-mute enabled, a write equal to the active settings starts no mute, so the status stays 0.
- R5: With auto-mute disabled and no sequence running, a write appears on the active settings at the clock edge that accepts it, without a mute.
- R6: A direct mute is requested by the OR of the pin input and the register input. The gain ramps to 0, stays at 0 while the request is held, and ramps up after the request is released.
- R7: A started ramp cannot be aborted. If the request is released during the fall, the gain still reaches 0. If the request is raised during the rise, the gain still reaches full scale before the next fall begins.
- R8: The ramp-length select encodes 0, 1, 2 and 3 as 1, 8, 16 and 32 half-millisecond units. Each of the STEPS phase steps lasts units*TICKS_PER_HALF_MS/STEPS ticks. With the tick held high, a full mute/de-mute cycle from a one-cycle request keeps the status high for 2*STEPS*that+3 cycles.
- R9: The ramp-length select is sampled when a ramp starts. A change during the ramp does not alter that ramp.
- R10: The status flag is 1 whenever the gain is below full scale, and the gain is at full scale whenever the status is 0.
- R11: At phase i the gain equals floor(GMAX*(3*i*i*STEPS - 2*i*i*i)/STEPS^3), where GMAX is all ones. The phase falls from STEPS to 0 one step at a time and rises back, so the gain moves monotonically with small first and last steps.
- R12: While the tick input is low the ramp phase does not advance, so the gain holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Ramp time base, one pulse per tick period |
| ramp_sel | input | 2 | Ramp length select (R8 encoding) |
| auto_en | input | 1 | Enables auto-mute around filter updates |
| pin_mute | input | 1 | Mute request from the device pin |
| reg_mute | input | 1 | Mute request from the register bit |
| cfg_wr | input | 1 | Write strobe for the filter configuration |
| cfg_data | input | 22 | Filter configuration word to write |
| gain | output | GAIN_W (10) | Mute gain level applied to the three paths |
| active_cfg | output | 22 | Filter settings currently in force |
| mute_busy | output | 1 | High from the start of muting to the end of de-muting |

## Verification
The bench builds the block with STEPS and TICKS_PER_HALF_MS both at 16, so that each phase step lasts exactly 1, 8, 16 or 32 ticks. With the tick held high, the whole S-curve of the shortest ramp can be compared sample by sample. Ramp lengths are then checked as exact cycle counts of the status flag. A 10-bit gain keeps the table values distinct enough to show the small end steps of the curve. The short ramp also lets overlapping writes be placed within the fall, at the floor and during the rise.

// File: rtl/amute_pkg.sv
// Shared types and constant functions for the auto-mute sequencer.
// Assumes the filter configuration is a flat word whose fields are all
// sensitive, so any change to it must be applied while muted.
package amute_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FALL  = 2'd1,
        SQ_FLOOR = 2'd2,
        SQ_RISE  = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic [1:0] loud_fc;
        logic       loud_hiboost;
        logic [1:0] treb_fc;
        logic [1:0] mid_fc;
        logic       mid_q;
        logic [2:0] bass_fc;
        logic [1:0] bass_q;
        logic       bass_dcmode;
        logic [2:0] lowp_fc;
        logic       lowp_invert;
        logic [2:0] highp_fc;
        logic       highp_invert;
    } filt_cfg_t;

    localparam int CFG_W = $bits(filt_cfg_t);

    // S-curve (smoothstep) level at phase i of steps, scaled to gmax.
    function automatic longint s_level(longint i, longint steps, longint gmax);
        return (gmax * (3 * i * i * steps - 2 * i * i * i)) / (steps * steps * steps);
    endfunction

    // Ramp length in half-millisecond units for each select code.
    function automatic int span_units(logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/amute_ramp.sv
// Phase counter and S-curve table for the soft-mute gain.
// Assumes go_down is only issued at the top and go_up only at the floor;
// a ramp in progress ignores further start requests and always completes.
module amute_ramp
    import amute_pkg::*;
#(
    parameter int STEPS             = 16,
    parameter int GAIN_W            = 10,
    parameter int TICKS_PER_HALF_MS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        sel,
    input  logic              go_down,
    input  logic              go_up,
    output logic [GAIN_W-1:0] gain,
    output logic              busy
);
    localparam int     PH_W      = $clog2(STEPS + 1);
    localparam int     TPS_UNIT  = TICKS_PER_HALF_MS / STEPS;
    localparam int     MAX_PER   = 32 * TPS_UNIT;
    localparam int     CNT_W     = $clog2(MAX_PER + 1);
    localparam longint GMAX      = (longint'(1) << GAIN_W) - 1;

    logic [PH_W-1:0]   phase;
    logic              dir_up;
    logic              running;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  per_step;
    logic              last_step;
    logic [GAIN_W-1:0] lut [STEPS+1];

    // One table entry per phase, computed at elaboration.
    for (genvar g = 0; g <= STEPS; g++) begin : g_lut
        assign lut[g] = GAIN_W'(s_level(g, STEPS, GMAX));
    end

    // Flags the step that ends the current ramp.
    always_comb begin
        last_step = dir_up ? (phase == PH_W'(STEPS - 1)) : (phase == PH_W'(1));
    end

    // Starts a ramp, then steps the phase once per per_step ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_W'(STEPS);
            dir_up   <= 1'b0;
            running  <= 1'b0;
            cnt      <= '0;
            per_step <= CNT_W'(TPS_UNIT);
        end else if (!running && (go_down || go_up)) begin
            running  <= 1'b1;
            dir_up   <= go_up;
            cnt      <= '0;
            per_step <= CNT_W'(span_units(sel) * TPS_UNIT);
        end else if (running && tick) begin
            if (cnt == per_step - CNT_W'(1)) begin
                cnt   <= '0;
                phase <= dir_up ? phase + PH_W'(1) : phase - PH_W'(1);
                if (last_step) begin
                    running <= 1'b0;
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Gain is the table entry of the present phase.
    always_comb begin
        gain = lut[phase];
        busy = running;
    end

endmodule

// File: rtl/amute_shadow.sv
// Shadow and active copies of the filter configuration.
// Assumes apply is raised only when the path is silent or auto-mute is off;
// a write in the same cycle as apply is applied directly.
module amute_shadow
    import amute_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_cfg,
    input  logic             apply,
    output logic [CFG_W-1:0] active_cfg,
    output logic             pending
);
    logic [CFG_W-1:0] shadow;
    logic [CFG_W-1:0] next_shadow;

    // The newest value, including a write in this cycle.
    always_comb begin
        next_shadow = wr_en ? wr_cfg : shadow;
    end

    // Captures every write; the last one wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else begin
            shadow <= next_shadow;
        end
    end

    // Copies the newest value into force when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_cfg <= '0;
        end else if (apply) begin
            active_cfg <= next_shadow;
        end
    end

    // A held value differs from the one in force.
    always_comb begin
        pending = (shadow != active_cfg);
    end

endmodule

// File: rtl/amute_fsm.sv
// Sequencer: idle, fall to silence, floor (apply), rise back to unity.
// Assumes the ramp raises busy on the edge after a start request and
// drops it on the edge that completes the last step.
module amute_fsm
    import amute_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      auto_en,
    input  logic      mute_req,
    input  logic      pending,
    input  logic      ramp_busy,
    output logic      go_down,
    output logic      go_up,
    output logic      apply,
    output logic      busy_flag,
    output sq_state_e state
);
    sq_state_e nxt;

    // Chooses the next state and the one-cycle controls.
    always_comb begin
        nxt     = state;
        go_down = 1'b0;
        go_up   = 1'b0;
        apply   = 1'b0;
        case (state)
            SQ_IDLE: begin
                apply = !auto_en;
                if (mute_req || (auto_en && pending)) begin
                    go_down = 1'b1;
                    nxt     = SQ_FALL;
                end
            end
            SQ_FALL: begin
                if (!ramp_busy) begin
                    nxt = SQ_FLOOR;
                end
            end
            SQ_FLOOR: begin
                apply = 1'b1;
                if (!mute_req) begin
                    go_up = 1'b1;
                    nxt   = SQ_RISE;
                end
            end
            default: begin
                if (!ramp_busy) begin
                    nxt = SQ_IDLE;
                end
            end
        endcase
    end

    // Holds the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Status is high outside idle.
    always_comb begin
        busy_flag = (state != SQ_IDLE);
    end

endmodule

// File: rtl/automute_seq.sv
// Top of the auto-mute filter update sequencer.
// Assumes tick is synchronous to clk and TICKS_PER_HALF_MS is a multiple
// of STEPS; the mute request is the OR of pin and register sources.
module automute_seq
    import amute_pkg::*;
#(
    parameter int STEPS             = 16,
    parameter int GAIN_W            = 10,
    parameter int TICKS_PER_HALF_MS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        ramp_sel,
    input  logic              auto_en,
    input  logic              pin_mute,
    input  logic              reg_mute,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic [GAIN_W-1:0] gain,
    output logic [CFG_W-1:0]  active_cfg,
    output logic              mute_busy
);
    logic      mute_req;
    logic      go_down;
    logic      go_up;
    logic      apply;
    logic      pending;
    logic      ramp_busy;
    sq_state_e sq_state;

    // Either source may request a mute.
    always_comb begin
        mute_req = pin_mute | reg_mute;
    end

    amute_ramp #(
        .STEPS            (STEPS),
        .GAIN_W           (GAIN_W),
        .TICKS_PER_HALF_MS(TICKS_PER_HALF_MS)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .sel    (ramp_sel),
        .go_down(go_down),
        .go_up  (go_up),
        .gain   (gain),
        .busy   (ramp_busy)
    );

    amute_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wr_cfg    (cfg_data),
        .apply     (apply),
        .active_cfg(active_cfg),
        .pending   (pending)
    );

    amute_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_en),
        .mute_req (mute_req),
        .pending  (pending),
        .ramp_busy(ramp_busy),
        .go_down  (go_down),
        .go_up    (go_up),
        .apply    (apply),
        .busy_flag(mute_busy),
        .state    (sq_state)
    );

endmodule

// File: rtl/automute_seq_chk.sv
// Property checker for automute_seq, attached with bind.
// Assumes the sequencer state is visible as sq_state inside the top.
module automute_seq_chk
    import amute_pkg::*;
#(
    parameter int GAIN_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              auto_en,
    input logic [GAIN_W-1:0] gain,
    input logic [CFG_W-1:0]  active_cfg,
    input logic              mute_busy,
    input sq_state_e         state
);
    localparam logic [GAIN_W-1:0] GMAX = '1;

    assert_idle_full_gain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_busy |-> gain == GMAX);

    assert_apply_at_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(active_cfg) && $past(auto_en)) |-> $past(gain) == '0);

    assert_fall_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_FALL && $past(state) == SQ_FALL) |-> gain <= $past(gain));

    assert_rise_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RISE && $past(state) == SQ_RISE) |-> gain >= $past(gain));

    assert_fall_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state) == SQ_FALL |-> (state == SQ_FALL || state == SQ_FLOOR));

    assert_rise_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state) == SQ_RISE |-> (state == SQ_RISE || state == SQ_IDLE));

    assert_floor_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == SQ_FLOOR |-> gain == '0);

    assert_tick_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> gain == $past(gain));

endmodule

bind automute_seq automute_seq_chk #(.GAIN_W(GAIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .auto_en   (auto_en),
    .gain      (gain),
    .active_cfg(active_cfg),
    .mute_busy (mute_busy),
    .state     (sq_state)
);

// File: tb/test_automute_seq.sv
// Directed bench for automute_seq: one task per scenario.
module test_automute_seq;
    import amute_pkg::*;

    localparam int STEPS  = 16;
    localparam int GAIN_W = 10;
    localparam int GMAX   = (1 << GAIN_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b1;
    logic [1:0]        ramp_sel = 2'd0;
    logic              auto_en = 1'b0;
    logic              pin_mute = 1'b0;
    logic              reg_mute = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [CFG_W-1:0]  cfg_data = '0;
    logic [GAIN_W-1:0] gain;
    logic [CFG_W-1:0]  active_cfg;
    logic              mute_busy;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    automute_seq #(.STEPS(STEPS), .GAIN_W(GAIN_W), .TICKS_PER_HALF_MS(16)) i_automute_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ramp_sel(ramp_sel),
        .auto_en(auto_en), .pin_mute(pin_mute), .reg_mute(reg_mute),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .gain(gain),
        .active_cfg(active_cfg), .mute_busy(mute_busy)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int exp_level(int i);
        longint li = i;
        return int'((longint'(GMAX) * (3 * li * li * STEPS - 2 * li * li * li)) / (STEPS * STEPS * STEPS));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Runs until the status has been low 40 cycles; records sequence facts.
    task automatic settle(input logic [CFG_W-1:0] bad, output int rises,
                          output bit bad_seen, output bit gain_ok);
        int quiet = 0;
        logic prev_busy = mute_busy;
        logic [CFG_W-1:0] prev_cfg = active_cfg;
        rises = 0; bad_seen = 1'b0; gain_ok = 1'b1;
        while (quiet < 40) begin
            @(negedge clk);
            if (mute_busy && !prev_busy) rises++;
            if (active_cfg != prev_cfg && auto_en && gain != 0) gain_ok = 1'b0;
            if (active_cfg == bad) bad_seen = 1'b1;
            quiet = mute_busy ? 0 : quiet + 1;
            prev_busy = mute_busy;
            prev_cfg = active_cfg;
        end
    endtask

    // One-cycle register request; returns status-high cycle count.
    task automatic pulse_count(output int n);
        @(negedge clk);
        reg_mute = 1'b1;
        @(negedge clk);
        reg_mute = 1'b0;
        n = 0;
        while (mute_busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(gain == GMAX, "R1 gain", gain, GMAX);
        check(mute_busy == 1'b0, "R1 status", mute_busy, 0);
        check(active_cfg == '0, "R1 active", active_cfg, 0);
    endtask

    task automatic t_curve;
        bit ok = 1'b1;
        int bad_k = -1;
        ramp_sel = 2'd0;
        @(negedge clk);
        reg_mute = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            if (gain != exp_level(17 - k) && ok) begin
                ok = 1'b0;
                bad_k = k;
            end
        end
        check(ok, "R11 fall curve", bad_k, -1);
        check(exp_level(1) - exp_level(0) < exp_level(9) - exp_level(8), "R11 small end step",
              exp_level(1), exp_level(9) - exp_level(8));
        repeat (20) @(negedge clk);
        check(gain == 0 && mute_busy, "R6 held at floor (reg)", gain, 0);
        reg_mute = 1'b0;
        pin_mute = 1'b1;
        repeat (30) @(negedge clk);
        check(gain == 0, "R6 held at floor (pin)", gain, 0);
        pin_mute = 1'b0;
        repeat (40) @(negedge clk);
        check(gain == GMAX && !mute_busy, "R6 back to full after release", gain, GMAX);
    endtask

    task automatic t_timing;
        int n;
        int units [4] = '{1, 8, 16, 32};
        for (int s = 0; s < 4; s++) begin
            ramp_sel = 2'(s);
            pulse_count(n);
            check(n == 2 * STEPS * units[s] + 3, "R8 status length", n, 2 * STEPS * units[s] + 3);
        end
        ramp_sel = 2'd0;
    endtask

    task automatic t_sel_latch;
        int n;
        ramp_sel = 2'd0;
        @(negedge clk);
        reg_mute = 1'b1;
        @(negedge clk);
        reg_mute = 1'b0;
        ramp_sel = 2'd3;
        n = 1;
        while (n < 17) begin
            @(negedge clk);
            n++;
        end
        check(gain == 0, "R9 fall kept short length", gain, 0);
        while (mute_busy) @(negedge clk);
        ramp_sel = 2'd0;
    endtask

    task automatic t_auto;
        int r; bit bs; bit gok;
        auto_en = 1'b1;
        write_cfg(22'h15A5C3);
        settle(22'h3FFFFF, r, bs, gok);
        check(r == 1, "R2 one sequence", r, 1);
        check(gok, "R2 applied only at silence", gok, 1);
        check(active_cfg == 22'h15A5C3, "R2 value applied", active_cfg, 22'h15A5C3);
        check(gain == GMAX, "R2 gain restored", gain, GMAX);
    endtask

    task automatic t_same;
        int r; bit bs; bit gok;
        write_cfg(22'h15A5C3);
        settle(22'h3FFFFF, r, bs, gok);
        check(r == 0, "R4 equal write no mute", r, 0);
    endtask

    task automatic t_overwrite;
        int r; bit bs; bit gok;
        write_cfg(22'h000111);
        repeat (3) @(negedge clk);
        write_cfg(22'h000222);
        repeat (2) @(negedge clk);
        write_cfg(22'h000333);
        settle(22'h000111, r, bs, gok);
        check(active_cfg == 22'h000333, "R3 last write wins", active_cfg, 22'h000333);
        check(!bs, "R3 stale value never applied", bs, 0);
        write_cfg(22'h000444);
        while (gain != 0) @(negedge clk);
        while (gain < 500) @(negedge clk);
        write_cfg(22'h000555);
        settle(22'h3FFFFF, r, bs, gok);
        check(r == 1, "R3 write during rise starts another", r, 1);
        check(active_cfg == 22'h000555, "R3 final value after second", active_cfg, 22'h000555);
    endtask

    task automatic t_direct;
        auto_en = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = 22'h2ABCDE;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(active_cfg == 22'h2ABCDE, "R5 direct apply", active_cfg, 22'h2ABCDE);
        check(!mute_busy && gain == GMAX, "R5 no mute", mute_busy, 0);
    endtask

    task automatic t_noabort;
        bit full_seen = 1'b0;
        int min_g = GMAX;
        @(negedge clk);
        reg_mute = 1'b1;
        repeat (3) @(negedge clk);
        reg_mute = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (gain < min_g) min_g = gain;
        end
        check(min_g == 0, "R7 fall completes after release", min_g, 0);
        while (gain < 600) @(negedge clk);
        reg_mute = 1'b1;
        repeat (30) begin
            @(negedge clk);
            if (gain == GMAX) full_seen = 1'b1;
        end
        check(full_seen, "R7 rise completes under new request", full_seen, 1);
        reg_mute = 1'b0;
        while (mute_busy) @(negedge clk);
    endtask

    task automatic t_tick;
        logic [GAIN_W-1:0] g0;
        ramp_sel = 2'd0;
        @(negedge clk);
        reg_mute = 1'b1;
        repeat (4) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        g0 = gain;
        repeat (20) @(negedge clk);
        check(gain == g0 && g0 != 0, "R12 gain frozen without tick", gain, g0);
        check(mute_busy == 1'b1, "R10 status high while below full", mute_busy, 1);
        tick = 1'b1;
        reg_mute = 1'b0;
        repeat (60) @(negedge clk);
        check(gain == GMAX && !mute_busy, "R10 status low at full", mute_busy, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_curve();
        t_timing();
        t_sel_latch();
        t_auto();
        t_same();
        t_overwrite();
        t_direct();
        t_noabort();
        t_tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule